// File: doc/BRIEF.md
# Codec Control Byte Interpreter

This block turns a stream of 8-bit control bytes into the settings of a four-channel voice codec. Each byte comes with a one-cycle valid strobe. The top bit of a byte marks it either as a configuration command or as a time slot number. The block holds two settings shared by all channels: the companding law and the frame timing mode. For each channel it holds the power and direction state, the receive and transmit slot numbers, the directions of two line-interface I/O pins, and a 14-bit receive and a 14-bit transmit gain coefficient.

How a byte is read depends on what came before it. A power-up command that asks for slot numbers makes the next one or two slot bytes land in that channel's slot registers. A gain command makes the very next byte a gain half-word, whatever its top bit holds. A small context machine tracks these expectations. A byte that breaks the protocol raises a one-cycle error pulse. All outputs come from registers.

Top module: `codec_cmd_decoder`

## Requirements
- R1: A byte with bit 7 = 0 is a slot byte carrying its number in bits 6:0. A slot byte that arrives while no slot assignment is pending changes no setting and raises `proto_err`.
- R2: A configuration byte (bit 7 = 1) whose bits 6:5 are 00 or 01 is a codec-mode byte. It sets `law_alaw` to bit 5 (0 = µ-law, 1 = A-law) and `delay_mode` to bit 4 (0 = non-delay, 1 = delay). Both settings apply to all channels.
- R3: A codec-mode byte writes its bits 1:0 into the 2-bit `ch_mode` field of the channel given by bits 3:2. The codes are 00 power down, 01 up with receive slot, 10 up with transmit slot, 11 up with both. Channel c occupies `ch_mode[2c+1:2c]`.
- R4: After code 01 the next slot byte sets that channel's receive slot. After code 10 it sets the transmit slot. After code 11 the first slot byte sets the receive slot and the second sets the transmit slot. After that, nothing is pending. Channel c's slot is `rx_slot/tx_slot[7c+6:7c]`.
- R5: A configuration byte with bits 6:5 = 10 and bit 4 = 1 sets the pin directions of the channel in bits 3:2. Bit 1 drives `io_in[2c+1]` and bit 0 drives `io_in[2c]`, where 1 means input and 0 means output.
- R6: A configuration byte with bits 6:5 = 10 and bit 4 = 0 arms a gain write for the channel in bits 3:2. Bit 1 selects receive (0) or transmit (1), and bit 0 selects the low (0) or high (1) 7-bit half. The next byte is taken as data whatever its bit 7. Its bits 6:0 are stored into the chosen half (bits 13:7 or 6:0 of the channel's 14 bits in `rx_gain/tx_gain[14c+13:14c]`). The other half is left unchanged and no error is raised.
- R7: A configuration byte with bits 6:5 = 11 changes no setting, keeps any pending slot assignment, and raises `proto_err`.
- R8: A configuration byte that arrives while a slot assignment is pending takes effect normally. The rest of the assignment is dropped without an error.
- R9: Settings change only in the cycle after an accepted byte. With `byte_vld` low, every output holds and `proto_err` is low.
- R10: After reset all channels are powered down (code 00), all slots and gains are 0, µ-law and non-delay are selected, and all I/O pins are inputs.
- R11: `proto_err` is a single-cycle pulse in the cycle after the offending byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | Control byte strobe |
| byte_dat | input | 8 | Control byte |
| law_alaw | output | 1 | 1 = A-law, 0 = µ-law (all channels) |
| delay_mode | output | 1 | 1 = delay timing, 0 = non-delay (all channels) |
| ch_mode | output | 8 | Per-channel power/direction code, 2 bits each |
| rx_slot | output | 28 | Per-channel receive slot, 7 bits each |
| tx_slot | output | 28 | Per-channel transmit slot, 7 bits each |
| io_in | output | 8 | Per-channel pin directions, 1 = input |
| rx_gain | output | 56 | Per-channel receive gain, 14 bits each |
| tx_gain | output | 56 | Per-channel transmit gain, 14 bits each |
| proto_err | output | 1 | One-cycle protocol error pulse |

## Verification
Two cases make decoding and context tracking compete for the same byte.

- **Gain data with bit 7 set.** The first case is a gain data byte whose top bit is set, so it also looks like a configuration command. The bench sends 0xFF and 0x9A right after armed gain commands. It expects only the gain half to change, with the law, timing, modes and error flag untouched.
- **Configuration byte during a slot assignment.** The second case is a configuration byte that arrives while a slot assignment is still pending. For a valid command, the bench expects the command to take effect and the slot byte that follows to be flagged. For a reserved-mode byte, it expects an error while the pending assignment survives and catches the next slot byte.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
   localparam int BYTE_W  = 8;
   localparam int CHSEL_W = 2;
   localparam int PAY_W   = 7;

   typedef enum logic [2:0] {
      CTX_IDLE,
      CTX_RX_TX,
      CTX_RX,
      CTX_TX,
      CTX_GAIN
   } ctx_e;

   typedef enum logic [1:0] {
      MODE_MULAW = 2'b00,
      MODE_ALAW  = 2'b01,
      MODE_LINE  = 2'b10,
      MODE_RSVD  = 2'b11
   } mode_e;

   typedef struct packed {
      logic               is_cfg;
      mode_e              mode;
      logic               sel;
      logic [CHSEL_W-1:0] ch;
      logic [1:0]         arg;
      logic [PAY_W-1:0]   payload;
   } fields_t;

   typedef struct packed {
      logic               glob_we;
      logic               law;
      logic               dly;
      logic               state_we;
      logic               io_we;
      logic               rx_we;
      logic               tx_we;
      logic               gain_we;
      logic               gain_tx;
      logic               gain_hi;
      logic [CHSEL_W-1:0] ch;
      logic [1:0]         arg;
      logic [PAY_W-1:0]   payload;
      logic               err;
   } wr_t;
endpackage

// File: rtl/ccd_classify.sv
module ccd_classify
   import ccd_pkg::*;
(
   input  logic [BYTE_W-1:0] byte_dat,
   output fields_t           f
);
   always_comb begin
      f.is_cfg  = byte_dat[7];
      f.mode    = mode_e'(byte_dat[6:5]);
      f.sel     = byte_dat[4];
      f.ch      = byte_dat[3:2];
      f.arg     = byte_dat[1:0];
      f.payload = byte_dat[6:0];
   end
endmodule

// File: rtl/ccd_context.sv
module ccd_context
   import ccd_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    vld,
   input  fields_t f,
   output wr_t     wr,
   output ctx_e    ctx_q
);
   ctx_e               ctx_d;
   logic [CHSEL_W-1:0] ch_q, ch_d;
   logic               gtx_q, gtx_d, ghi_q, ghi_d;

   always_comb begin
      ctx_d = ctx_q;
      ch_d  = ch_q;
      gtx_d = gtx_q;
      ghi_d = ghi_q;
      wr    = '0;
      wr.ch      = ch_q;
      wr.arg     = f.arg;
      wr.payload = f.payload;
      wr.gain_tx = gtx_q;
      wr.gain_hi = ghi_q;
      if (vld) begin
         if (ctx_q == CTX_GAIN) begin
            wr.gain_we = 1'b1;
            ctx_d      = CTX_IDLE;
         end else if (f.is_cfg) begin
            unique case (f.mode)
               MODE_MULAW, MODE_ALAW: begin
                  wr.glob_we  = 1'b1;
                  wr.law      = f.mode[0];
                  wr.dly      = f.sel;
                  wr.state_we = 1'b1;
                  wr.ch       = f.ch;
                  ch_d        = f.ch;
                  unique case (f.arg)
                     2'b01:   ctx_d = CTX_RX;
                     2'b10:   ctx_d = CTX_TX;
                     2'b11:   ctx_d = CTX_RX_TX;
                     default: ctx_d = CTX_IDLE;
                  endcase
               end
               MODE_LINE: begin
                  ch_d = f.ch;
                  if (f.sel) begin
                     wr.io_we = 1'b1;
                     wr.ch    = f.ch;
                     ctx_d    = CTX_IDLE;
                  end else begin
                     gtx_d = f.arg[1];
                     ghi_d = f.arg[0];
                     ctx_d = CTX_GAIN;
                  end
               end
               default: wr.err = 1'b1;
            endcase
         end else begin
            unique case (ctx_q)
               CTX_RX_TX: begin wr.rx_we = 1'b1; ctx_d = CTX_TX;   end
               CTX_RX:    begin wr.rx_we = 1'b1; ctx_d = CTX_IDLE; end
               CTX_TX:    begin wr.tx_we = 1'b1; ctx_d = CTX_IDLE; end
               default:   wr.err = 1'b1;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctx_q <= CTX_IDLE;
         ch_q  <= '0;
         gtx_q <= 1'b0;
         ghi_q <= 1'b0;
      end else begin
         ctx_q <= ctx_d;
         ch_q  <= ch_d;
         gtx_q <= gtx_d;
         ghi_q <= ghi_d;
      end
   end
endmodule

// File: rtl/ccd_chan_bank.sv
module ccd_chan_bank
   import ccd_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int SLOT_W = 7,
   parameter int HALF_W = 7,
   localparam int GAIN_W = 2 * HALF_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  wr_t                      wr,
   output logic [NUM_CH*2-1:0]      ch_mode,
   output logic [NUM_CH*SLOT_W-1:0] rx_slot,
   output logic [NUM_CH*SLOT_W-1:0] tx_slot,
   output logic [NUM_CH*2-1:0]      io_in,
   output logic [NUM_CH*GAIN_W-1:0] rx_gain,
   output logic [NUM_CH*GAIN_W-1:0] tx_gain
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic              hit;
      logic [1:0]        mode_q, io_q;
      logic [SLOT_W-1:0] rxs_q, txs_q;
      logic [GAIN_W-1:0] rxg_q, txg_q;

      assign hit = (wr.ch == CHSEL_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q <= 2'b00;
            io_q   <= 2'b11;
            rxs_q  <= '0;
            txs_q  <= '0;
            rxg_q  <= '0;
            txg_q  <= '0;
         end else if (hit) begin
            if (wr.state_we) mode_q <= wr.arg;
            if (wr.io_we)    io_q   <= wr.arg;
            if (wr.rx_we)    rxs_q  <= wr.payload[SLOT_W-1:0];
            if (wr.tx_we)    txs_q  <= wr.payload[SLOT_W-1:0];
            if (wr.gain_we && !wr.gain_tx) begin
               if (wr.gain_hi) rxg_q[GAIN_W-1:HALF_W] <= wr.payload[HALF_W-1:0];
               else            rxg_q[HALF_W-1:0]      <= wr.payload[HALF_W-1:0];
            end
            if (wr.gain_we && wr.gain_tx) begin
               if (wr.gain_hi) txg_q[GAIN_W-1:HALF_W] <= wr.payload[HALF_W-1:0];
               else            txg_q[HALF_W-1:0]      <= wr.payload[HALF_W-1:0];
            end
         end
      end

      assign ch_mode[c*2 +: 2]           = mode_q;
      assign io_in[c*2 +: 2]             = io_q;
      assign rx_slot[c*SLOT_W +: SLOT_W] = rxs_q;
      assign tx_slot[c*SLOT_W +: SLOT_W] = txs_q;
      assign rx_gain[c*GAIN_W +: GAIN_W] = rxg_q;
      assign tx_gain[c*GAIN_W +: GAIN_W] = txg_q;
   end
endmodule

// File: rtl/codec_cmd_decoder.sv
module codec_cmd_decoder
   import ccd_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int SLOT_W = 7,
   parameter int HALF_W = 7,
   localparam int GAIN_W = 2 * HALF_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     byte_vld,
   input  logic [7:0]               byte_dat,
   output logic                     law_alaw,
   output logic                     delay_mode,
   output logic [NUM_CH*2-1:0]      ch_mode,
   output logic [NUM_CH*SLOT_W-1:0] rx_slot,
   output logic [NUM_CH*SLOT_W-1:0] tx_slot,
   output logic [NUM_CH*2-1:0]      io_in,
   output logic [NUM_CH*GAIN_W-1:0] rx_gain,
   output logic [NUM_CH*GAIN_W-1:0] tx_gain,
   output logic                     proto_err
);
   if (NUM_CH != (1 << CHSEL_W)) begin : g_bad_num_ch
      $error("NUM_CH must match the 2-bit channel field");
   end
   if (SLOT_W < 1 || SLOT_W > PAY_W) begin : g_bad_slot_w
      $error("SLOT_W must lie in 1..7");
   end
   if (HALF_W < 1 || HALF_W > PAY_W) begin : g_bad_half_w
      $error("HALF_W must lie in 1..7");
   end

   fields_t fld;
   wr_t     wr;
   ctx_e    ctx;

   ccd_classify i_classify (
      .byte_dat (byte_dat),
      .f        (fld)
   );

   ccd_context i_context (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (byte_vld),
      .f     (fld),
      .wr    (wr),
      .ctx_q (ctx)
   );

   ccd_chan_bank #(
      .NUM_CH (NUM_CH),
      .SLOT_W (SLOT_W),
      .HALF_W (HALF_W)
   ) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr),
      .ch_mode (ch_mode),
      .rx_slot (rx_slot),
      .tx_slot (tx_slot),
      .io_in   (io_in),
      .rx_gain (rx_gain),
      .tx_gain (tx_gain)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         law_alaw   <= 1'b0;
         delay_mode <= 1'b0;
         proto_err  <= 1'b0;
      end else begin
         proto_err <= wr.err;
         if (wr.glob_we) begin
            law_alaw   <= wr.law;
            delay_mode <= wr.dly;
         end
      end
   end
endmodule

// File: rtl/ccd_checker.sv
module ccd_checker
   import ccd_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int HALF_W = 7,
   localparam int GAIN_W = 2 * HALF_W
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     byte_vld,
   input logic [7:0]               byte_dat,
   input ctx_e                     ctx,
   input logic                     law_alaw,
   input logic                     delay_mode,
   input logic [NUM_CH*2-1:0]      ch_mode,
   input logic [NUM_CH*2-1:0]      io_in,
   input logic [NUM_CH*GAIN_W-1:0] rx_gain,
   input logic [NUM_CH*GAIN_W-1:0] tx_gain,
   input logic                     proto_err
);
   AST_IDLE_SLOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld && !byte_dat[7] && ctx == CTX_IDLE |=> proto_err); // R1

   AST_LAW_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld && byte_dat[7:6] == 2'b10 && ctx != CTX_GAIN
      |=> law_alaw == $past(byte_dat[5]) && delay_mode == $past(byte_dat[4])); // R2

   AST_SLOT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld && !byte_dat[7] && (ctx == CTX_RX || ctx == CTX_TX)
      |=> ctx == CTX_IDLE && !proto_err); // R4

   AST_GAIN_DATA_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld && ctx == CTX_GAIN
      |=> !proto_err && $stable(law_alaw) && $stable(ch_mode) && $stable(io_in)); // R6

   AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld && byte_dat[7:5] == 3'b111 && ctx != CTX_GAIN
      |=> proto_err && $stable(ch_mode) && $stable(io_in) && $stable(law_alaw)
          && ctx == $past(ctx)); // R7

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> !proto_err && $stable(ch_mode) && $stable(io_in)
          && $stable(rx_gain) && $stable(tx_gain) && $stable(law_alaw)
          && $stable(delay_mode)); // R9
endmodule

bind codec_cmd_decoder ccd_checker #(
   .NUM_CH (NUM_CH),
   .HALF_W (HALF_W)
) i_ccd_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .byte_vld   (byte_vld),
   .byte_dat   (byte_dat),
   .ctx        (ctx),
   .law_alaw   (law_alaw),
   .delay_mode (delay_mode),
   .ch_mode    (ch_mode),
   .io_in      (io_in),
   .rx_gain    (rx_gain),
   .tx_gain    (tx_gain),
   .proto_err  (proto_err)
);

// File: tb/test_codec_cmd_decoder.sv
module test_codec_cmd_decoder;
   localparam int VW = 187;

   typedef struct {
      logic [VW-1:0] v;
      string         tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_dat = '0;
   logic        law_alaw, delay_mode, proto_err;
   logic [7:0]  ch_mode, io_in;
   logic [27:0] rx_slot, tx_slot;
   logic [55:0] rx_gain, tx_gain;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   item_t q[$];
   logic vld_seen = 1'b0;

   logic       m_law, m_dly, m_err;
   logic [1:0] m_mode [4];
   logic [1:0] m_io   [4];
   logic [6:0] m_rx   [4];
   logic [6:0] m_tx   [4];
   logic [13:0] m_rg  [4];
   logic [13:0] m_tg  [4];
   int         m_ctx;
   int         m_ch;
   logic       m_gtx, m_ghi;

   always #4 clk = ~clk;

   codec_cmd_decoder i_codec_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
      .law_alaw(law_alaw), .delay_mode(delay_mode), .ch_mode(ch_mode),
      .rx_slot(rx_slot), .tx_slot(tx_slot), .io_in(io_in),
      .rx_gain(rx_gain), .tx_gain(tx_gain), .proto_err(proto_err));

   function automatic logic [VW-1:0] model_vec(input logic e);
      logic [7:0]  cm, io;
      logic [27:0] rs, ts;
      logic [55:0] rg, tg;
      for (int c = 0; c < 4; c++) begin
         cm[c*2 +: 2]  = m_mode[c];
         io[c*2 +: 2]  = m_io[c];
         rs[c*7 +: 7]  = m_rx[c];
         ts[c*7 +: 7]  = m_tx[c];
         rg[c*14 +: 14] = m_rg[c];
         tg[c*14 +: 14] = m_tg[c];
      end
      return {m_law, m_dly, cm, rs, ts, io, rg, tg, e};
   endfunction

   function automatic logic [VW-1:0] dut_vec();
      return {law_alaw, delay_mode, ch_mode, rx_slot, tx_slot, io_in,
              rx_gain, tx_gain, proto_err};
   endfunction

   task automatic model_reset();
      m_law = 0; m_dly = 0; m_err = 0; m_ctx = 0; m_ch = 0; m_gtx = 0; m_ghi = 0;
      for (int c = 0; c < 4; c++) begin
         m_mode[c] = 2'b00; m_io[c] = 2'b11; m_rx[c] = '0; m_tx[c] = '0;
         m_rg[c] = '0; m_tg[c] = '0;
      end
   endtask

   // Expected effect of one byte, from the requirements
   task automatic apply(input logic [7:0] b);
      int ch;
      ch = int'(b[3:2]);
      m_err = 0;
      if (m_ctx == 4) begin
         if (m_gtx) begin
            if (m_ghi) m_tg[m_ch][13:7] = b[6:0]; else m_tg[m_ch][6:0] = b[6:0];
         end else begin
            if (m_ghi) m_rg[m_ch][13:7] = b[6:0]; else m_rg[m_ch][6:0] = b[6:0];
         end
         m_ctx = 0;
      end else if (b[7]) begin
         case (b[6:5])
            2'b00, 2'b01: begin
               m_law = b[5]; m_dly = b[4]; m_mode[ch] = b[1:0]; m_ch = ch;
               m_ctx = (b[1:0] == 2'b11) ? 1 : (b[1:0] == 2'b01) ? 2 :
                       (b[1:0] == 2'b10) ? 3 : 0;
            end
            2'b10: begin
               if (b[4]) begin m_io[ch] = b[1:0]; m_ctx = 0; end
               else begin m_ctx = 4; m_ch = ch; m_gtx = b[1]; m_ghi = b[0]; end
            end
            default: m_err = 1;
         endcase
      end else begin
         case (m_ctx)
            1: begin m_rx[m_ch] = b[6:0]; m_ctx = 3; end
            2: begin m_rx[m_ch] = b[6:0]; m_ctx = 0; end
            3: begin m_tx[m_ch] = b[6:0]; m_ctx = 0; end
            default: m_err = 1;
         endcase
      end
   endtask

   // Driver: present a byte and queue the expected result
   task automatic send(input logic [7:0] b, input string tag);
      item_t it;
      @(negedge clk);
      byte_vld = 1'b1;
      byte_dat = b;
      apply(b);
      it.v = model_vec(m_err);
      it.tag = tag;
      q.push_back(it);
   endtask

   task automatic quiet(input int n);
      @(negedge clk);
      byte_vld = 1'b0;
      byte_dat = '0;
      repeat (n) @(negedge clk);
   endtask

   task automatic check_now(input string tag);
      logic [VW-1:0] a, e;
      a = dut_vec();
      e = model_vec(1'b0);
      n_chk++;
      if (a !== e) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, a, e);
      end
   endtask

   // Monitor: compare the cycle after each accepted byte
   always @(posedge clk) vld_seen <= byte_vld;

   always @(negedge clk) begin
      if (vld_seen && rst_n) begin
         if (q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL scoreboard: actual result with no expected item");
         end else begin
            item_t it;
            logic [VW-1:0] a;
            it = q.pop_front();
            a = dut_vec();
            n_chk++;
            if (a !== it.v) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", it.tag, a, it.v);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_now("R10 reset state");

      send(8'h87, "R3 ch1 power up both");
      send(8'h05, "R4 ch1 rx slot");
      send(8'h7F, "R4 ch1 tx slot 127");
      send(8'h10, "R1 slot with nothing pending");
      quiet(2);
      check_now("R9 R11 hold and error drop");

      send(8'hB9, "R2 A-law delay ch2 rx");
      send(8'h00, "R4 ch2 rx slot 0");
      send(8'h8E, "R2 mu-law nondelay ch3 tx");
      send(8'h2A, "R4 ch3 tx slot");
      send(8'h83, "R3 ch0 both");
      send(8'h11, "R4 ch0 rx first");
      send(8'hB0, "R8 cfg drops pending");
      send(8'h22, "R8 slot after drop flagged");

      send(8'h8D, "R3 ch3 rx");
      send(8'hFF, "R7 reserved ignored");
      send(8'hE0, "R7 reserved back to back");
      send(8'h33, "R7 pending kept");

      send(8'hD5, "R5 ch1 pins");
      send(8'hD8, "R5 ch2 pins output");
      send(8'hC1, "R6 arm ch0 rx hi");
      send(8'h55, "R6 ch0 rx hi data");
      send(8'hC0, "R6 arm ch0 rx lo");
      send(8'hFF, "R6 data with top bit");
      send(8'hCF, "R6 arm ch3 tx hi");
      send(8'h9A, "R6 ch3 tx hi data");
      send(8'hCE, "R6 arm ch3 tx lo");
      send(8'h01, "R6 ch3 tx lo data");
      send(8'h44, "R1 slot after gain flagged");
      quiet(3);
      check_now("R9 R11 final hold");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule